// File: doc/BRIEF.md
# Shared Power-Down / Interrupt Pin Controller

This block owns one bidirectional pad that has two jobs. Out of reset the pad is an input: a low level on it asks the rest of the transceiver to power down. Software can turn the same pad into an interrupt output by writing a two-bit enable pattern into a control register. A polarity bit in that register chooses whether an asserted interrupt is a low or a high level.

Event pulses from the transceiver's internal sources are latched into a status register, but only for sources whose bit is set in a mask register. While any enabled pending event exists, the pad is asserted without waiting for a clock edge. A single read of the status register returns every pending bit and clears all of them at once. An event that arrives in the same cycle as that read stays pending.

The pad mode is tracked by a three-state machine. `PIN_SENSE` is input mode, `PIN_QUIET` is output mode with nothing pending, and `PIN_ALERT` is output mode with an interrupt asserted. The transitions are:
- SENSE→QUIET or SENSE→ALERT when the enable pattern becomes valid (ALERT if something is already pending).
- QUIET→ALERT when an event becomes pending.
- ALERT→QUIET when the pending set empties.
- QUIET→SENSE and ALERT→SENSE when the pattern stops being valid.

Top module: `pdi_pin_ctrl`

## Requirements
- R1: After reset, `pin_oe` is 0 and the status (0x13), mask (0x12) and control (0x14) registers all read 0.
- R2: Output mode is entered only when control bit 15 is 1 and control bit 12 is 0. The change shows on `pin_oe` at the second rising edge after the write's edge. Any other pattern returns the pad to input mode with the same latency.
- R3: Control bit 13 sets polarity. With bit 13 = 0, an asserted interrupt drives `pin_drive` to 0 and the idle level is 1. With bit 13 = 1, the asserted level is 1 and the idle level is 0.
- R4: In input mode, `pdn_req` equals the inverse of `pin_in` after two rising edges of synchronization.
- R5: In output mode, `pdn_req` stays 0 whatever level `pin_in` has.
- R6: Mask register bit i enables source i. An event on a source whose mask bit is 0 is not latched.
- R7: Status register bit i is set at the rising edge where `evt_i[i]` is 1 and mask bit i is 1. The bit stays set until a status read.
- R8: One read of address 0x13 returns all pending bits in `mgmt_rdata`. Every pending bit is clear after the edge that ends the read.
- R9: An enabled event present in the same cycle as a status read is pending after that read.
- R10: In output mode, `pin_drive` takes the asserted level combinationally in the cycle an enabled event is present, before any clock edge.
- R11: Writes to the status register have no effect. The control register reads back the full word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | One-cycle event pulses, one per source |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_wr | input | 1 | Write strobe |
| mgmt_rd | input | 1 | Read strobe; a status read clears pending bits |
| mgmt_rdata | output | 16 | Combinational read data for `mgmt_addr` |
| pin_in | input | 1 | Pad receiver level |
| pin_drive | output | 1 | Level driven onto the pad when enabled |
| pin_oe | output | 1 | Pad output enable |
| pdn_req | output | 1 | Power-down request (input mode only) |

## Verification
Some properties are checked by assertions on every cycle:
- `pin_oe` never rises unless the enable pattern was valid one cycle earlier.
- `pdn_req` is never high while the pad drives.
- The pad level always matches the polarity and the pending state.
- Status bits never appear for masked sources, never drop without a read, and are all gone after a read that coincides with no event.

Other behaviour needs the bench's scenarios:
- The two-edge latencies of mode switching and synchronization.
- The exact value a status read returns.
- An event surviving a simultaneous read.
- The combinational assertion of the pad before any edge.

// File: rtl/pdi_pkg.sv
package pdi_pkg;

    typedef enum logic [1:0] {
        PIN_SENSE = 2'd0,
        PIN_QUIET = 2'd1,
        PIN_ALERT = 2'd2
    } pin_mode_e;

endpackage

// File: rtl/pdi_regs.sv
module pdi_regs #(
    parameter int AW     = 5,
    parameter int DW     = 16,
    parameter int NSRC   = 8,
    parameter int A_STAT = 19,
    parameter int A_MASK = 18,
    parameter int A_CTRL = 20,
    parameter int B_OE   = 15,
    parameter int B_OEN  = 12,
    parameter int B_POL  = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            wr,
    input  logic            rd,
    input  logic [NSRC-1:0] status_q,
    output logic [DW-1:0]   rdata,
    output logic [NSRC-1:0] mask_q,
    output logic            drv_en,
    output logic            pol,
    output logic            stat_clr
);

    localparam logic [AW-1:0] ADR_STAT = AW'(A_STAT);
    localparam logic [AW-1:0] ADR_MASK = AW'(A_MASK);
    localparam logic [AW-1:0] ADR_CTRL = AW'(A_CTRL);

    logic [DW-1:0] ctrl_q;
    logic [DW-1:0] mask_word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            mask_word_q <= '0;
        end else if (wr) begin
            if (addr == ADR_CTRL) ctrl_q      <= wdata;
            if (addr == ADR_MASK) mask_word_q <= wdata;
        end
    end

    assign mask_q   = mask_word_q[NSRC-1:0];
    assign drv_en   = ctrl_q[B_OE] && !ctrl_q[B_OEN];
    assign pol      = ctrl_q[B_POL];
    assign stat_clr = rd && (addr == ADR_STAT);

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADR_STAT: rdata[NSRC-1:0] = status_q;
            ADR_MASK: rdata[NSRC-1:0] = mask_word_q[NSRC-1:0];
            ADR_CTRL: rdata = ctrl_q;
            default:  rdata = '0;
        endcase
    end

    AST_CTRL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl_q)); // R11

endmodule

// File: rtl/pdi_status.sv
module pdi_status #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] mask,
    input  logic            clr,
    output logic [NSRC-1:0] status_q,
    output logic            pend_any
);

    logic [NSRC-1:0] hits;
    logic [NSRC-1:0] status_d;

    assign hits = evt & mask;

    always_comb begin
        status_d = clr ? '0 : status_q;
        status_d = status_d | hits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    assign pend_any = |((status_q | evt) & mask);

    AST_MASK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(mask)) == '0)); // R6

    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status_q & $past(status_q)) == $past(status_q))); // R7

    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (hits == '0)) |=> (status_q == '0)); // R8

    AST_KEEP_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && (hits != '0)) |=> ((status_q & $past(hits)) == $past(hits))); // R9

endmodule

// File: rtl/pdi_pin_fsm.sv
module pdi_pin_fsm
    import pdi_pkg::*;
#(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drv_en,
    input  logic pol,
    input  logic pend_any,
    input  logic pin_in,
    output logic pin_drive,
    output logic pin_oe,
    output logic pdn_req
);

    pin_mode_e       state_q, state_d;
    logic [SYNC-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC-2:0], pin_in};
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_SENSE: if (drv_en)    state_d = pend_any ? PIN_ALERT : PIN_QUIET;
            PIN_QUIET: if (!drv_en)   state_d = PIN_SENSE;
                       else if (pend_any)  state_d = PIN_ALERT;
            PIN_ALERT: if (!drv_en)   state_d = PIN_SENSE;
                       else if (!pend_any) state_d = PIN_QUIET;
            default:                  state_d = PIN_SENSE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PIN_SENSE;
        else        state_q <= state_d;
    end

    always_comb begin
        pin_oe    = 1'b0;
        pin_drive = 1'b1;
        pdn_req   = 1'b0;
        unique case (state_q)
            PIN_SENSE: begin
                pdn_req = ~sync_q[SYNC-1];
            end
            PIN_QUIET, PIN_ALERT: begin
                pin_oe    = 1'b1;
                pin_drive = pend_any ? pol : ~pol;
            end
            default: begin
                pin_oe = 1'b0;
            end
        endcase
    end

    AST_ENABLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |=> !pin_oe); // R2

    AST_PDN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> !pdn_req); // R5

    AST_ASSERT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pend_any) |-> (pin_drive == pol)); // R10

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && !pend_any) |-> (pin_drive != pol)); // R3

endmodule

// File: rtl/pdi_pin_ctrl.sv
module pdi_pin_ctrl #(
    parameter int AW     = 5,
    parameter int DW     = 16,
    parameter int NSRC   = 8,
    parameter int SYNC   = 2,
    parameter int A_STAT = 19,
    parameter int A_MASK = 18,
    parameter int A_CTRL = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] evt_i,
    input  logic [AW-1:0]   mgmt_addr,
    input  logic [DW-1:0]   mgmt_wdata,
    input  logic            mgmt_wr,
    input  logic            mgmt_rd,
    output logic [DW-1:0]   mgmt_rdata,
    input  logic            pin_in,
    output logic            pin_drive,
    output logic            pin_oe,
    output logic            pdn_req
);

    logic [NSRC-1:0] status_q;
    logic [NSRC-1:0] mask_q;
    logic            drv_en;
    logic            pol;
    logic            stat_clr;
    logic            pend_any;

    pdi_regs #(
        .AW(AW), .DW(DW), .NSRC(NSRC),
        .A_STAT(A_STAT), .A_MASK(A_MASK), .A_CTRL(A_CTRL),
        .B_OE(15), .B_OEN(12), .B_POL(13)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .addr(mgmt_addr), .wdata(mgmt_wdata),
        .wr(mgmt_wr), .rd(mgmt_rd),
        .status_q(status_q), .rdata(mgmt_rdata),
        .mask_q(mask_q), .drv_en(drv_en), .pol(pol),
        .stat_clr(stat_clr)
    );

    pdi_status #(.NSRC(NSRC)) u_status (
        .clk(clk), .rst_n(rst_n),
        .evt(evt_i), .mask(mask_q), .clr(stat_clr),
        .status_q(status_q), .pend_any(pend_any)
    );

    pdi_pin_fsm #(.SYNC(SYNC)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .drv_en(drv_en), .pol(pol), .pend_any(pend_any),
        .pin_in(pin_in),
        .pin_drive(pin_drive), .pin_oe(pin_oe), .pdn_req(pdn_req)
    );

endmodule

// File: tb/tb_pdi_pin_ctrl.sv
module tb_pdi_pin_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_EV = 2'd2;
    localparam logic [4:0] AS = 5'h13;
    localparam logic [4:0] AM = 5'h12;
    localparam logic [4:0] AC = 5'h14;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [15:0] data;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{OP_RD, AS, 16'h0000, 16'h0000},   // R1 status after reset
        '{OP_RD, AC, 16'h0000, 16'h0000},   // R1 control after reset
        '{OP_RD, AM, 16'h0000, 16'h0000},   // R1 mask after reset
        '{OP_EV, AS, 16'h0005, 16'h0000},   // R6 masked events
        '{OP_RD, AS, 16'h0000, 16'h0000},   // R6 nothing latched
        '{OP_WR, AM, 16'h000F, 16'h0000},
        '{OP_RD, AM, 16'h0000, 16'h000F},   // R6 mask readback
        '{OP_EV, AS, 16'h0031, 16'h0000},   // R6 only bit0 enabled
        '{OP_EV, AS, 16'h0004, 16'h0000},   // R7 accumulate
        '{OP_RD, AS, 16'h0000, 16'h0005},   // R7 sticky union
        '{OP_RD, AS, 16'h0000, 16'h0000},   // R8 cleared
        '{OP_WR, AC, 16'hB000, 16'h0000},
        '{OP_RD, AC, 16'h0000, 16'hB000},   // R11 control readback
        '{OP_WR, AS, 16'h00FF, 16'h0000},
        '{OP_RD, AS, 16'h0000, 16'h0000}    // R11 status write ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  evt_i = '0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic        mgmt_wr = 1'b0;
    logic        mgmt_rd = 1'b0;
    logic [15:0] mgmt_rdata;
    logic        pin_in = 1'b1;
    logic        pin_drive;
    logic        pin_oe;
    logic        pdn_req;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdi_pin_ctrl dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
        .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .mgmt_wr(mgmt_wr), .mgmt_rd(mgmt_rd), .mgmt_rdata(mgmt_rdata),
        .pin_in(pin_in), .pin_drive(pin_drive), .pin_oe(pin_oe),
        .pdn_req(pdn_req)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [15:0] d);
        mgmt_addr = a; mgmt_wdata = d; mgmt_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        mgmt_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, input logic [15:0] e, input string req);
        mgmt_addr = a; mgmt_rd = 1'b1;
        #1 chk(req, mgmt_rdata, e);
        @(posedge clk); @(negedge clk);
        mgmt_rd = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] v);
        evt_i = v;
        @(posedge clk); @(negedge clk);
        evt_i = '0;
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        edges(3);
        rst_n = 1'b1;
        edges(3);
        chk("R1 pin_oe", {15'd0, pin_oe}, 16'd0);
        chk("R4 pdn idle", {15'd0, pdn_req}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            unique case (VECS[i].op)
                OP_WR: wr_reg(VECS[i].addr, VECS[i].data);
                OP_EV: pulse(VECS[i].data[7:0]);
                default: rd_reg(VECS[i].addr, VECS[i].exp, "R1/R6/R7/R8/R11 table read");
            endcase
        end

        // R2: bits 15,13,12 all set -> complementary bit blocks output mode
        edges(2);
        chk("R2 oen blocks", {15'd0, pin_oe}, 16'd0);

        // R4: input-mode power-down request after two edges
        pin_in = 1'b0;
        edges(2);
        chk("R4 pdn low", {15'd0, pdn_req}, 16'd1);
        pin_in = 1'b1;
        edges(2);
        chk("R4 pdn high", {15'd0, pdn_req}, 16'd0);

        // R2/R3: enter output mode, active-low polarity
        wr_reg(AC, 16'h8000);
        chk("R2 latency", {15'd0, pin_oe}, 16'd0);
        edges(1);
        chk("R2 pin_oe", {15'd0, pin_oe}, 16'd1);
        chk("R3 idle low-pol", {15'd0, pin_drive}, 16'd1);

        // R5: pad level ignored in output mode
        pin_in = 1'b0;
        edges(3);
        chk("R5 pdn blocked", {15'd0, pdn_req}, 16'd0);
        pin_in = 1'b1;

        // R10: combinational assertion before any edge
        evt_i = 8'h02;
        #1 chk("R10 async", {15'd0, pin_drive}, 16'd0);
        @(posedge clk); @(negedge clk);
        evt_i = '0;
        #1 chk("R7 held", {15'd0, pin_drive}, 16'd0);

        // R8/R9: read with a coincident event
        mgmt_addr = AS; mgmt_rd = 1'b1; evt_i = 8'h01;
        #1 chk("R8 read value", mgmt_rdata, 16'h0002);
        @(posedge clk); @(negedge clk);
        mgmt_rd = 1'b0; evt_i = '0;
        rd_reg(AS, 16'h0001, "R9 coincident event kept");
        rd_reg(AS, 16'h0000, "R8 all cleared");
        chk("R8 pin idle", {15'd0, pin_drive}, 16'd1);

        // R3: active-high polarity
        wr_reg(AC, 16'hA000);
        #1 chk("R3 idle high-pol", {15'd0, pin_drive}, 16'd0);
        evt_i = 8'h08;
        #1 chk("R3 asserted high", {15'd0, pin_drive}, 16'd1);
        @(posedge clk); @(negedge clk);
        evt_i = '0;
        rd_reg(AS, 16'h0008, "R7 source 3");

        // R2: invalid pattern returns to input mode
        wr_reg(AC, 16'h9000);
        chk("R2 exit latency", {15'd0, pin_oe}, 16'd1);
        edges(1);
        chk("R2 exit", {15'd0, pin_oe}, 16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule